// File: doc/BRIEF.md
# Memory-to-Host Transmit Channel Sequencer

This block streams bytes from an internal memory out to an external host in single-cycle mode, one byte for each host read. Software selects the transmit direction, picks cycle mode, and loads a start address and an end address. It then raises the enable bit. The sequencer fetches the first byte through a request/acknowledge memory port, places it in the transmit buffer, advances the address and raises a channel request towards the host.

The host answers with a read strobe. A falling strobe edge counts as the host taking the byte when it comes with chip-select and address bit 0 both low, or with the DMA acknowledge low. That edge drops the request. The following rising edge starts the next fetch. Once the byte at the end address is in the buffer, the next rising edge closes the operation and pulses the end interrupt. All host inputs are asynchronous to the clock. They pass through a two-flop synchronizer before any edge is detected.

Top module: `tx_chan_seq`

## Requirements
- R1: A rising edge of `enable_i`, while the sequencer is idle with `dir_i` = 2'b10 and `burst_i` = 0, starts a memory read at `start_addr_i` on the next clock. Any other `dir_i` or `burst_i` value leaves the block idle.
- R2: `mem_req_o` stays high until `mem_ack_i` is sampled high. On that edge, `mem_rdata_i` is loaded into `txbuf_o`, `mem_addr_o` increments by one, and `chan_req_o` rises.
- R3: Host inputs are sampled through two flops. `chan_req_o` falls on the third rising clock after a falling edge of `host_rd_ni`, but only if at that edge (`host_cs_ni` = 0 and `host_a0_i` = 0) or `host_dack_ni` = 0. An unqualified falling edge leaves the request high.
- R4: After the request has dropped, the next synchronized rising edge of `host_rd_ni` starts the next memory read. A rising edge seen while the request is still high is ignored.
- R5: Once the byte at `end_addr_i` has been loaded, no further memory read is issued. The next synchronized rising edge of `host_rd_ni` returns the block to idle and drives `done_irq_o` high for exactly one cycle.
- R6: With start 0x0100 and end 0x0101, exactly two memory reads are made, at 0x0100 and then 0x0101, followed by one interrupt.
- R7: Driving `enable_i` low in any active state returns the block to idle on the next clock, with `chan_req_o` and `mem_req_o` low and no interrupt. This holds even when the clear falls on the cycle of the final strobe rise.
- R8: `txbuf_o` does not change while `chan_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 2 | Direction field; 2'b10 selects transmit |
| burst_i | input | 1 | Burst select; 0 selects cycle mode |
| enable_i | input | 1 | Operation enable; rising edge starts, low aborts |
| start_addr_i | input | AW | First memory address |
| end_addr_i | input | AW | Last memory address |
| mem_req_o | output | 1 | Internal memory read request |
| mem_addr_o | output | AW | Address counter / memory address |
| mem_ack_i | input | 1 | Internal memory read acknowledge |
| mem_rdata_i | input | DW | Internal memory read data |
| txbuf_o | output | DW | Transmit buffer contents |
| chan_req_o | output | 1 | Channel request to host |
| host_cs_ni | input | 1 | Host chip-select, active low |
| host_a0_i | input | 1 | Host address bit 0 |
| host_dack_ni | input | 1 | Host DMA acknowledge, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| done_irq_o | output | 1 | End-of-operation interrupt pulse |

## Verification
Two events can land on the same clock edge: the software abort, when `enable_i` falls, and the synchronized final strobe rise that would raise the interrupt. The bench counts clocks from the last strobe rise so that the enable clear arrives on the exact edge where the rise is detected. It then checks that the abort wins: the block goes idle and `done_irq_o` stays low. A behavioural reference model is compared against every output on every clock. It covers this collision, the unqualified falling edges and the memory-latency stalls.

// File: rtl/tx_chan_pkg.sv
package tx_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SERVE = 2'd2,
    ST_DRAIN = 2'd3
  } tx_state_e;

  localparam logic [1:0] DIR_TX = 2'b10;
endpackage

// File: rtl/tx_host_sync.sv
module tx_host_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/tx_strobe_edge.sv
module tx_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_ni,
  input  logic cs_ni,
  input  logic a0_i,
  input  logic dack_ni,
  output logic fall_o,
  output logic rise_o
);
  logic rd_prev_q;
  logic qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_prev_q <= 1'b1;
    else         rd_prev_q <= rd_ni;
  end

  // host owns the byte: register select with A0 low, or DMA cycle
  assign qual   = (!cs_ni && !a0_i) || !dack_ni;
  assign fall_o = rd_prev_q && !rd_ni && qual;
  assign rise_o = !rd_prev_q && rd_ni;
endmodule

// File: rtl/tx_addr_ctr.sv
module tx_addr_ctr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic          inc_i,
  input  logic [AW-1:0] end_i,
  output logic [AW-1:0] addr_o,
  output logic          at_end_o
);
  localparam logic [AW-1:0] ONE = 1;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= start_i;
    else if (inc_i)  addr_q <= addr_q + ONE;
  end

  assign addr_o   = addr_q;
  assign at_end_o = (addr_q == end_i);

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> (addr_o == $past(addr_o) + ONE));
endmodule

// File: rtl/tx_chan_seq.sv
module tx_chan_seq
  import tx_chan_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    dir_i,
  input  logic          burst_i,
  input  logic          enable_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] end_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] txbuf_o,
  output logic          chan_req_o,
  input  logic          host_cs_ni,
  input  logic          host_a0_i,
  input  logic          host_dack_ni,
  input  logic          host_rd_ni,
  output logic          done_irq_o
);
  localparam int unsigned NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1101; // {rd, dack, a0, cs}

  tx_state_e     state_q, state_d;
  logic [NSYNC-1:0] host_s;
  logic          edge_fall, edge_rise;
  logic          en_prev_q, last_q, irq_q;
  logic [DW-1:0] buf_q;
  logic          start, load_byte, at_end;

  tx_host_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({host_rd_ni, host_dack_ni, host_a0_i, host_cs_ni}),
    .q_o (host_s)
  );

  tx_strobe_edge u_edge (
    .clk_i, .rst_ni,
    .rd_ni   (host_s[3]),
    .cs_ni   (host_s[0]),
    .a0_i    (host_s[1]),
    .dack_ni (host_s[2]),
    .fall_o  (edge_fall),
    .rise_o  (edge_rise)
  );

  assign start     = (state_q == ST_IDLE) && enable_i && !en_prev_q &&
                     (dir_i == DIR_TX) && !burst_i;
  assign load_byte = (state_q == ST_FETCH) && enable_i && mem_ack_i;

  tx_addr_ctr #(.AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .load_i   (start),
    .start_i  (start_addr_i),
    .inc_i    (load_byte),
    .end_i    (end_addr_i),
    .addr_o   (mem_addr_o),
    .at_end_o (at_end)
  );

  always_comb begin
    state_d = state_q;
    if (state_q != ST_IDLE && !enable_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:  if (start)     state_d = ST_FETCH;
        ST_FETCH: if (mem_ack_i) state_d = ST_SERVE;
        ST_SERVE: if (edge_fall) state_d = ST_DRAIN;
        ST_DRAIN: if (edge_rise) state_d = last_q ? ST_IDLE : ST_FETCH;
        default:                 state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      en_prev_q <= 1'b0;
      last_q    <= 1'b0;
      buf_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      en_prev_q <= enable_i;
      irq_q     <= (state_q == ST_DRAIN) && edge_rise && last_q && enable_i;
      if (load_byte) begin
        buf_q  <= mem_rdata_i;
        last_q <= at_end;
      end
    end
  end

  assign mem_req_o  = (state_q == ST_FETCH);
  assign chan_req_o = (state_q == ST_SERVE);
  assign txbuf_o    = buf_q;
  assign done_irq_o = irq_q;

  // R2
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && enable_i) |=> mem_req_o);
  // R3
  req_drop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chan_req_o) |-> ($past(edge_fall) || !$past(enable_i)));
  // R5
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);
  // R7
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!chan_req_o && !mem_req_o && !done_irq_o));
  // R8
  txbuf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_req_o && enable_i) |=> $stable(txbuf_o));
endmodule

// File: tb/tb_tx_chan_seq.sv
`timescale 1ns/1ps
module tb_tx_chan_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  dir_i = 2'b10;
  logic        burst_i = 1'b0;
  logic        enable_i = 1'b0;
  logic [15:0] start_addr_i = '0;
  logic [15:0] end_addr_i = '0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;
  logic [7:0]  txbuf_o;
  logic        chan_req_o;
  logic        host_cs_ni = 1'b1;
  logic        host_a0_i = 1'b0;
  logic        host_dack_ni = 1'b1;
  logic        host_rd_ni = 1'b1;
  logic        done_irq_o;

  int tests = 0, fails = 0, cycles = 0, lat_cnt = 0;
  int irq_seen = 0, reads_seen = 0;
  int read_addr[$];

  always #4 clk_i = ~clk_i; // 125 MHz

  tx_chan_seq dut (.*);

  // behavioural reference
  int   m_state = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_buf = '0;
  logic m_last = 0, m_irq = 0, m_enp = 0;
  logic m_rd1 = 1, m_rd2 = 1, m_rdp = 1, m_cs1 = 1, m_cs2 = 1;
  logic m_a01 = 0, m_a02 = 0, m_dk1 = 1, m_dk2 = 1;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_addr = '0; m_buf = '0; m_last = 0; m_irq = 0; m_enp = 0;
      m_rd1 = 1; m_rd2 = 1; m_rdp = 1; m_cs1 = 1; m_cs2 = 1;
      m_a01 = 0; m_a02 = 0; m_dk1 = 1; m_dk2 = 1;
    end else begin
      logic fall, rise;
      fall = m_rdp && !m_rd2 && ((!m_cs2 && !m_a02) || !m_dk2);
      rise = !m_rdp && m_rd2;
      m_irq = 0;
      if (m_state != 0 && !enable_i) m_state = 0;
      else case (m_state)
        0: if (enable_i && !m_enp && dir_i == 2'b10 && !burst_i) begin
             m_state = 1; m_addr = start_addr_i;
           end
        1: if (mem_ack_i) begin
             m_buf = mem_rdata_i; m_last = (m_addr == end_addr_i);
             m_addr = m_addr + 16'd1; m_state = 2;
           end
        2: if (fall) m_state = 3;
        default: if (rise) begin
             if (m_last) begin m_state = 0; m_irq = 1; end
             else m_state = 1;
           end
      endcase
      m_enp = enable_i;
      m_rdp = m_rd2; m_rd2 = m_rd1; m_rd1 = host_rd_ni;
      m_cs2 = m_cs1; m_cs1 = host_cs_ni;
      m_a02 = m_a01; m_a01 = host_a0_i;
      m_dk2 = m_dk1; m_dk1 = host_dack_ni;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // per-clock comparison, memory model, watchdog
  always @(negedge clk_i) begin
    cycles++;
    if (rst_ni) begin
      chk("R1/R2", "mem_req_o", mem_req_o, m_state == 1);
      chk("R2", "mem_addr_o", mem_addr_o, m_addr);
      chk("R3/R4", "chan_req_o", chan_req_o, m_state == 2);
      chk("R5", "done_irq_o", done_irq_o, m_irq);
      chk("R8", "txbuf_o", txbuf_o, m_buf);
      if (done_irq_o) irq_seen++;
      if (mem_req_o && !mem_ack_i) begin
        lat_cnt++;
        if (lat_cnt >= 2) begin
          mem_ack_i = 1'b1; reads_seen++; read_addr.push_back(int'(mem_addr_o));
        end
      end else begin
        mem_ack_i = 1'b0; lat_cnt = 0;
      end
      mem_rdata_i = mem_addr_o[7:0] ^ 8'hA5;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // mode 0: chip-select + A0, mode 1: DMA ack, mode 2: unqualified
  task automatic host_read(input int mode);
    int t = 0;
    while (!chan_req_o && t < 200) begin @(negedge clk_i); t++; end
    if (mode == 0) begin host_cs_ni = 1'b0; host_a0_i = 1'b0; end
    if (mode == 1) host_dack_ni = 1'b0;
    if (mode == 2) begin host_cs_ni = 1'b0; host_a0_i = 1'b1; end
    host_rd_ni = 1'b0;
    wait_cyc(5);
    host_rd_ni = 1'b1;
    wait_cyc(1);
    host_cs_ni = 1'b1; host_a0_i = 1'b0; host_dack_ni = 1'b1;
    wait_cyc(4);
  endtask

  task automatic start_run(input logic [15:0] s, input logic [15:0] e);
    start_addr_i = s; end_addr_i = e;
    enable_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "reset chan_req_o", chan_req_o, 0);
    chk("R1", "reset mem_req_o", mem_req_o, 0);

    // R1 wrong direction / burst: no start
    dir_i = 2'b01; start_run(16'h0010, 16'h0011);
    wait_cyc(8);
    chk("R1", "no read with dir 01", reads_seen, 0);
    enable_i = 1'b0; wait_cyc(2);
    dir_i = 2'b10; burst_i = 1'b1; start_run(16'h0010, 16'h0011);
    wait_cyc(8);
    chk("R1", "no read in burst", reads_seen, 0);
    enable_i = 1'b0; burst_i = 1'b0; wait_cyc(2);

    // R6 two-byte transfer via chip-select qualification
    start_run(16'h0100, 16'h0101);
    host_read(0);
    host_read(0);
    wait_cyc(6);
    chk("R6", "byte reads", reads_seen, 2);
    chk("R6", "first addr", read_addr[0], 16'h0100);
    chk("R6", "second addr", read_addr[1], 16'h0101);
    chk("R5", "irq count", irq_seen, 1);
    chk("R5", "no read after end", mem_req_o, 0);
    enable_i = 1'b0; wait_cyc(2);

    // R3/R4 DMA qualification with an unqualified read in between
    reads_seen = 0; read_addr.delete();
    start_run(16'h0200, 16'h0203);
    host_read(1);
    host_read(2);
    chk("R3", "unqualified fall keeps request", chan_req_o, 1);
    chk("R4", "rise without drop starts nothing", reads_seen, 2);
    host_read(1); host_read(1); host_read(1);
    wait_cyc(6);
    chk("R4", "four reads", reads_seen, 4);
    chk("R5", "irq count", irq_seen, 2);
    enable_i = 1'b0; wait_cyc(2);

    // R7 abort mid-run
    reads_seen = 0;
    start_run(16'h0300, 16'h0305);
    host_read(0);
    wait_cyc(1);
    enable_i = 1'b0;
    wait_cyc(2);
    chk("R7", "abort chan_req_o", chan_req_o, 0);
    chk("R7", "abort mem_req_o", mem_req_o, 0);
    wait_cyc(6);
    chk("R7", "no irq on abort", irq_seen, 2);

    // R7 abort on the very edge of the final strobe rise
    start_run(16'h0400, 16'h0400);
    begin
      int t = 0;
      while (!chan_req_o && t < 200) begin @(negedge clk_i); t++; end
    end
    host_dack_ni = 1'b0; host_rd_ni = 1'b0;
    wait_cyc(5);
    host_rd_ni = 1'b1;       // rise detected and acted on two edges later
    wait_cyc(2);
    enable_i = 1'b0;         // low exactly at the acting edge
    wait_cyc(6);
    host_dack_ni = 1'b1;
    chk("R7", "collision irq suppressed", irq_seen, 2);
    chk("R7", "collision idle", chan_req_o, 0);

    // re-arm after abort works
    start_run(16'h0500, 16'h0500);
    host_read(0);
    wait_cyc(6);
    chk("R1", "restart irq", irq_seen, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule